// File: doc/BRIEF.md
# Two-Pass Integer Block Transform Engine

This block computes a fixed-point two-dimensional 8×8 transform with one multiply-accumulate step per clock cycle. Software first fills two signed 16-bit coefficient tables (called table A and table B here) and a block of 64 signed 8-bit samples, each through its own write port. A start pulse then runs two passes. The row pass reads the samples a row at a time and builds two intermediate arrays, one per table. The column pass combines those arrays down the columns, including a cross term between the tables. It then adds a fixed rounding offset and applies two arithmetic right shifts to form each result.

The 64 results leave on a valid-qualified stream in raster order, one every eight cycles. A one-cycle done pulse marks the end of the block. The tables and samples stay in place between runs. A new block therefore needs only a fresh sample load, and the same tables can be used again with no reload.

Top module: `dct2p_engine`

## Requirements
- R1: A write with `cf_we` high stores `cf_data` as table entry [r][c] at `cf_addr` = 8·r + c. `cf_sel` = 0 selects table A and `cf_sel` = 1 selects table B. A write with `smp_we` high stores `smp_data` as sample x[r][c] at `smp_addr` = 8·r + c. Loaded contents persist across runs until they are overwritten.
- R2: The row pass forms p[8i+j] = Σk x[i][k]·A[j][k] and q[8i+j] = Σk x[i][k]·B[j][k], for k = 0..7. Both sums start from zero for each (i, j).
- R3: For each output (i, j), the column pass forms u = Σk A[i][k]·p[8k+j], starting from zero.
- R4: For each output (i, j), the column pass forms v = Σk (A[i][k]·q[8k+j] + B[i][k]·p[8k+j]), starting from zero. The constant 8388591 is then added to v.
- R5: Each result is y[8i+j] = ((v >>> 8) + u) >>> 16, with signed arithmetic shifts and 48-bit signed sums. `out_data` carries the low 9 bits of y in two's complement, and no intermediate sum overflows for any 8-bit sample and any 16-bit coefficient.
- R6: A run produces exactly 64 `out_valid` pulses, in raster order (i outer, j inner). The first pulse is 520 cycles after the clock edge that samples `start` and the last is 1024 cycles after it. Pulses are 8 cycles apart, and none occurs during the row pass.
- R7: `done` is high for exactly one cycle, the cycle right after the 64th result (1025 cycles after the start edge).
- R8: `start` has no effect while a run is in progress. Once the run ends, the engine stays idle with `out_valid` and `done` low until the next `start`.
- R9: While `rst_n` is low, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_we | input | 1 | Sample write enable |
| smp_addr | input | 6 | Sample index 8·row + col |
| smp_data | input | 8 | Signed sample value |
| cf_we | input | 1 | Coefficient write enable |
| cf_sel | input | 1 | Table select: 0 = table A, 1 = table B |
| cf_addr | input | 6 | Coefficient index 8·row + col |
| cf_data | input | 16 | Signed coefficient value |
| start | input | 1 | Begin a run when idle |
| out_valid | output | 1 | Result strobe |
| out_data | output | 9 | Result, low 9 bits of y |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
The bench builds the engine with its default parameters: an 8×8 block, 8-bit samples, 16-bit coefficients, 48-bit accumulators and 9-bit results. With these settings the 1025-cycle run timing can be checked exactly. Full-range random coefficients and all-extreme operands exercise the widest intermediate values and the sign handling of the offset and both shifts. Zeroed and diagonal tables isolate the plain column sum from the cross term. A sample-only reload confirms that the tables are kept, and start pulses in both passes confirm that start is ignored while a run is in progress.

// File: rtl/dct2p_pkg.sv
package dct2p_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_COL  = 2'd2
  } dct2p_phase_e;
endpackage

// File: rtl/dct2p_regfile.sv
module dct2p_regfile #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dct2p_seq.sv
module dct2p_seq
  import dct2p_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          in_row,
  output logic          in_col,
  output logic [IW-1:0] ci,
  output logic [IW-1:0] cj,
  output logic [IW-1:0] ck,
  output logic          step_first,
  output logic          step_last,
  output logic          pass_last
);
  dct2p_phase_e phase;
  logic last_j, last_i;

  assign in_row     = (phase == PH_ROW);
  assign in_col     = (phase == PH_COL);
  assign step_first = (ck == '0);
  assign step_last  = (ck == IW'(N-1));
  assign last_j     = (cj == IW'(N-1));
  assign last_i     = (ci == IW'(N-1));
  assign pass_last  = step_last && last_j && last_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      ci    <= '0;
      cj    <= '0;
      ck    <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_ROW;
            ci    <= '0;
            cj    <= '0;
            ck    <= '0;
          end
        end
        PH_ROW, PH_COL: begin
          ck <= ck + 1'b1;
          if (step_last) begin
            ck <= '0;
            cj <= cj + 1'b1;
            if (last_j) begin
              cj <= '0;
              ci <= ci + 1'b1;
              if (last_i) begin
                ci    <= '0;
                phase <= (phase == PH_ROW) ? PH_COL : PH_IDLE;
              end
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dct2p_mac.sv
module dct2p_mac #(
  parameter int SAMP_W = 8,
  parameter int COEF_W = 16,
  parameter int TMP_W  = 27,
  parameter int ACC_W  = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_en,
  input  logic                    row_mode,
  input  logic                    step_first,
  input  logic [SAMP_W-1:0]       smp,
  input  logic [COEF_W-1:0]       ca,
  input  logic [COEF_W-1:0]       cb,
  input  logic [TMP_W-1:0]        tp,
  input  logic [TMP_W-1:0]        tq,
  output logic signed [ACC_W-1:0] sum_a,
  output logic signed [ACC_W-1:0] sum_b
);
  logic signed [ACC_W-1:0] acc_a, acc_b;
  logic signed [ACC_W-1:0] e_smp, e_ca, e_cb, e_tp, e_tq;
  logic signed [ACC_W-1:0] term_a, term_b;

  assign e_smp = ACC_W'($signed(smp));
  assign e_ca  = ACC_W'($signed(ca));
  assign e_cb  = ACC_W'($signed(cb));
  assign e_tp  = ACC_W'($signed(tp));
  assign e_tq  = ACC_W'($signed(tq));

  // row pass: two sample products; column pass: plain term and cross term
  always_comb begin
    if (row_mode) begin
      term_a = e_smp * e_ca;
      term_b = e_smp * e_cb;
    end else begin
      term_a = e_ca * e_tp;
      term_b = (e_ca * e_tq) + (e_cb * e_tp);
    end
  end

  assign sum_a = (step_first ? '0 : acc_a) + term_a;
  assign sum_b = (step_first ? '0 : acc_b) + term_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_a <= '0;
      acc_b <= '0;
    end else if (step_en) begin
      acc_a <= sum_a;
      acc_b <= sum_b;
    end
  end
endmodule

// File: rtl/dct2p_out_stage.sv
module dct2p_out_stage #(
  parameter int    ACC_W     = 48,
  parameter int    OUT_W     = 9,
  parameter longint ROUND_OFS = 8388591,
  parameter int    SH_A      = 8,
  parameter int    SH_B      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    elem_last,
  input  logic                    run_last,
  input  logic signed [ACC_W-1:0] u_sum,
  input  logic signed [ACC_W-1:0] v_sum,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_data,
  output logic                    done
);
  logic run_last_q;

  function automatic logic [OUT_W-1:0] fold(input logic signed [ACC_W-1:0] u,
                                            input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] r;
    r = v + ACC_W'(ROUND_OFS);
    r = (r >>> SH_A) + u;
    r = r >>> SH_B;
    return r[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      run_last_q <= 1'b0;
      done       <= 1'b0;
    end else begin
      out_valid  <= elem_last;
      run_last_q <= run_last;
      done       <= run_last_q;
      if (elem_last) out_data <= fold(u_sum, v_sum);
    end
  end
endmodule

// File: rtl/dct2p_engine.sv
module dct2p_engine #(
  parameter int     N         = 8,
  parameter int     SAMP_W    = 8,
  parameter int     COEF_W    = 16,
  parameter int     OUT_W     = 9,
  parameter int     ACC_W     = 48,
  parameter longint ROUND_OFS = 8388591,
  parameter int     SH_A      = 8,
  parameter int     SH_B      = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_we,
  input  logic [$clog2(N*N)-1:0]    smp_addr,
  input  logic [SAMP_W-1:0]         smp_data,
  input  logic                      cf_we,
  input  logic                      cf_sel,
  input  logic [$clog2(N*N)-1:0]    cf_addr,
  input  logic [COEF_W-1:0]         cf_data,
  input  logic                      start,
  output logic                      out_valid,
  output logic [OUT_W-1:0]          out_data,
  output logic                      done
);
  localparam int NN    = N * N;
  localparam int IW    = $clog2(N);
  localparam int AW    = $clog2(NN);
  localparam int TMP_W = SAMP_W + COEF_W + IW;

  function automatic logic [AW-1:0] flat(input logic [IW-1:0] r, input logic [IW-1:0] c);
    return AW'(r) * AW'(N) + AW'(c);
  endfunction

  // named internal events
  logic          in_row, in_col;
  logic [IW-1:0] ci, cj, ck;
  logic          step_first, step_last, pass_last;
  logic          tmp_we, elem_last, run_last;

  logic [AW-1:0] smp_raddr, cf_raddr, tmp_raddr, tmp_waddr;
  logic [SAMP_W-1:0] smp_rd;
  logic [1:0][COEF_W-1:0] cf_rd;
  logic [1:0][TMP_W-1:0]  tmp_rd;
  logic [1:0][TMP_W-1:0]  tmp_wd;
  logic signed [ACC_W-1:0] sum_a, sum_b;

  dct2p_seq #(.N(N)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_row(in_row), .in_col(in_col),
    .ci(ci), .cj(cj), .ck(ck),
    .step_first(step_first), .step_last(step_last), .pass_last(pass_last)
  );

  assign tmp_we    = in_row && step_last;
  assign elem_last = in_col && step_last;
  assign run_last  = in_col && pass_last;

  assign smp_raddr = flat(ci, ck);
  assign cf_raddr  = in_row ? flat(cj, ck) : flat(ci, ck);
  assign tmp_raddr = flat(ck, cj);
  assign tmp_waddr = flat(ci, cj);

  dct2p_regfile #(.W(SAMP_W), .DEPTH(NN)) u_smp (
    .clk(clk), .we(smp_we), .waddr(smp_addr), .wdata(smp_data),
    .raddr(smp_raddr), .rdata(smp_rd)
  );

  assign tmp_wd[0] = sum_a[TMP_W-1:0];
  assign tmp_wd[1] = sum_b[TMP_W-1:0];

  for (genvar t = 0; t < 2; t++) begin : g_tab
    dct2p_regfile #(.W(COEF_W), .DEPTH(NN)) u_cf (
      .clk(clk), .we(cf_we && (cf_sel == 1'(t))), .waddr(cf_addr), .wdata(cf_data),
      .raddr(cf_raddr), .rdata(cf_rd[t])
    );
    dct2p_regfile #(.W(TMP_W), .DEPTH(NN)) u_tmp (
      .clk(clk), .we(tmp_we), .waddr(tmp_waddr), .wdata(tmp_wd[t]),
      .raddr(tmp_raddr), .rdata(tmp_rd[t])
    );
  end

  dct2p_mac #(.SAMP_W(SAMP_W), .COEF_W(COEF_W), .TMP_W(TMP_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n),
    .step_en(in_row || in_col), .row_mode(in_row), .step_first(step_first),
    .smp(smp_rd), .ca(cf_rd[0]), .cb(cf_rd[1]), .tp(tmp_rd[0]), .tq(tmp_rd[1]),
    .sum_a(sum_a), .sum_b(sum_b)
  );

  dct2p_out_stage #(.ACC_W(ACC_W), .OUT_W(OUT_W), .ROUND_OFS(ROUND_OFS),
                    .SH_A(SH_A), .SH_B(SH_B)) u_out (
    .clk(clk), .rst_n(rst_n), .elem_last(elem_last), .run_last(run_last),
    .u_sum(sum_a), .v_sum(sum_b),
    .out_valid(out_valid), .out_data(out_data), .done(done)
  );
endmodule

// File: rtl/dct2p_chk.sv
module dct2p_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic out_valid,
  input logic done,
  input logic in_row,
  input logic in_col,
  input logic tmp_we
);
  // R6
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_col));

  // R6
  no_out_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_row |-> !out_valid);

  // R7
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_col && start) |=> !in_row);

  // R2
  tmp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmp_we |-> !in_col);
endmodule

bind dct2p_engine dct2p_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_valid(out_valid), .done(done),
  .in_row(in_row), .in_col(in_col), .tmp_we(tmp_we)
);

// File: tb/sim_dct2p_engine.sv
module sim_dct2p_engine;
  localparam int NN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_we = 1'b0, cf_we = 1'b0, cf_sel = 1'b0, start = 1'b0;
  logic [5:0] smp_addr = '0, cf_addr = '0;
  logic [7:0] smp_data = '0;
  logic [15:0] cf_data = '0;
  logic out_valid, done;
  logic [8:0] out_data;

  always #10 clk = ~clk;

  dct2p_engine u0 (
    .clk(clk), .rst_n(rst_n), .smp_we(smp_we), .smp_addr(smp_addr), .smp_data(smp_data),
    .cf_we(cf_we), .cf_sel(cf_sel), .cf_addr(cf_addr), .cf_data(cf_data),
    .start(start), .out_valid(out_valid), .out_data(out_data), .done(done)
  );

  int n_chk = 0, n_err = 0;
  int ta[NN], tb[NN], xs[NN];
  logic [8:0] exp_y[NN], got_y[NN];
  int got_n, t_first, t_last, t_done, n_done;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic reference();
    longint p[NN], q[NN];
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        longint sp = 0, sq = 0;
        for (int m = 0; m < 8; m++) begin
          sp += longint'(xs[8*r+m]) * ta[8*c+m];
          sq += longint'(xs[8*r+m]) * tb[8*c+m];
        end
        p[8*r+c] = sp; q[8*r+c] = sq;
      end
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        longint u = 0, v = 0, y;
        for (int m = 0; m < 8; m++) begin
          u += longint'(ta[8*r+m]) * p[8*m+c];
          v += longint'(ta[8*r+m]) * q[8*m+c] + longint'(tb[8*r+m]) * p[8*m+c];
        end
        v = v + 64'sd8388591;
        y = ((v >>> 8) + u) >>> 16;
        exp_y[8*r+c] = y[8:0];
      end
  endtask

  task automatic load_tables();
    for (int a = 0; a < NN; a++)
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        cf_we = 1'b1; cf_sel = 1'(s); cf_addr = 6'(a);
        cf_data = (s == 0) ? 16'(ta[a]) : 16'(tb[a]);
      end
    @(negedge clk); cf_we = 1'b0;
  endtask

  task automatic load_samples();
    for (int a = 0; a < NN; a++) begin
      @(negedge clk);
      smp_we = 1'b1; smp_addr = 6'(a); smp_data = 8'(xs[a]);
    end
    @(negedge clk); smp_we = 1'b0;
  endtask

  // n counts clock edges after the edge that samples start
  task automatic run_block(input string tag, input bit poke);
    got_n = 0; n_done = 0; t_first = -1; t_last = -1; t_done = -1;
    reference();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int n = 0; n < 1100; n++) begin
      if (out_valid) begin
        if (got_n < NN) got_y[got_n] = out_data;
        if (got_n == 0) t_first = n;
        t_last = n;
        got_n++;
      end
      if (done) begin n_done++; t_done = n; end
      start = (poke && (n == 100 || n == 700)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    // R6 count, order and spacing
    check(got_n == NN, "R6", {tag, " output count"}, got_n, NN);
    check(t_first == 520, "R6", {tag, " first output cycle"}, t_first, 520);
    check(t_last == 1024, "R6", {tag, " last output cycle"}, t_last, 1024);
    // R7 done pulse
    check(n_done == 1, "R7", {tag, " done pulses"}, n_done, 1);
    check(t_done == 1025, "R7", {tag, " done cycle"}, t_done, 1025);
    for (int e = 0; e < NN; e++)
      if (e < got_n)
        check(got_y[e] == exp_y[e], tag, $sformatf("result %0d", e), got_y[e], exp_y[e]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic signed [15:0] v16;
    logic signed [7:0]  v8;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    check(done == 1'b0, "R9", "done in reset", done, 0);
    rst_n = 1'b1;

    // full-range random tables and samples: R2 R3 R4 R5
    for (int a = 0; a < NN; a++) begin
      v16 = 16'($urandom()); ta[a] = v16;
      v16 = 16'($urandom()); tb[a] = v16;
      v8 = 8'($urandom()); xs[a] = v8;
    end
    load_tables(); load_samples();
    run_block("R5 random", 1'b0);

    // table B zeroed: result is the plain column sum plus offset, R2 R3
    for (int a = 0; a < NN; a++) begin
      v16 = 16'($urandom()); ta[a] = v16 >>> 4;
      tb[a] = 0;
    end
    load_tables();
    run_block("R3 tableB zero", 1'b0);

    // diagonal table A with random table B: cross term dominates, R4
    for (int a = 0; a < NN; a++) begin
      ta[a] = ((a / 8) == (a % 8)) ? 4096 : 0;
      v16 = 16'($urandom()); tb[a] = v16;
    end
    load_tables();
    run_block("R4 cross term", 1'b0);

    // all operands at the negative extreme, R5
    for (int a = 0; a < NN; a++) begin ta[a] = -32768; tb[a] = -32768; xs[a] = -128; end
    load_tables(); load_samples();
    run_block("R5 extremes", 1'b0);

    // new samples only, tables kept from previous load, R1
    for (int a = 0; a < NN; a++) begin v8 = 8'($urandom()); xs[a] = v8; end
    load_samples();
    run_block("R1 retained tables", 1'b0);

    // start pulses in both passes are ignored, R8
    for (int a = 0; a < NN; a++) begin
      v16 = 16'($urandom()); ta[a] = v16;
      v16 = 16'($urandom()); tb[a] = v16;
    end
    load_tables();
    run_block("R8 start while busy", 1'b1);

    // R8 idle after the run: no strobes without a new start
    begin
      int strobes = 0;
      for (int n = 0; n < 60; n++) begin
        @(negedge clk);
        if (out_valid || done) strobes++;
      end
      check(strobes == 0, "R8", "strobes while idle", strobes, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule